// File: doc/BRIEF.md
# NAND Die Cache-Read State Tracker

This block is a cycle-level model of the read side of a single NAND die, seen from the device. It takes command bytes one per clock. From them it produces the ready/busy line and the two status flags: die ready (RDY) and array ready (ARDY). Every byte is answered with a one-cycle accepted pulse or a one-cycle illegal pulse, based on which commands the current status combination allows.

The die is modelled as two page slots, a data register and a cache register. Each slot is a valid flag plus a page number; no page contents are stored. A plain page read keeps the die fully busy for the array-read time. It then fills both slots with the requested page.

In cache-read mode a cache command first blocks the die for a short cache-busy time. It then hands the data-register page to the cache register. The next page keeps loading in the background, so the cache can be read out while ARDY is still low. A final-cache command moves the last loaded page into the cache and leaves cache mode. A reset command works from any state.

Output bytes are a simple function of the cache page number and the column pointer. The column pointer returns to zero each time a new page lands in the cache.

Top module: `nand_cache_read_tracker`

## Requirements
- R1: After reset the die is ready: `rb_n`, `sts_rdy` and `sts_ardy` are 1, both slot-valid flags are 0, `col_ptr` is 0 and no command pulse is raised.
- R2: Byte 00h followed by 30h, with the die idle (RDY=1, ARDY=1), holds `rb_n`, `sts_rdy` and `sts_ardy` low for exactly T_RD cycles. After that, both slots hold the page latched from `page_addr` with the 00h byte, both are valid, and `col_ptr` is 0.
- R3: Byte 31h alone (sequential) or 00h then 31h (random) is accepted when RDY=1 and a page is held or loading in the data register. With the array idle, the die is busy for exactly T_CBSY cycles. It then shows RDY=1 and ARDY=0, the cache holds the previous data-register page, and the data register loads the target page for T_RD cycles. The sequential target is the last requested page plus one; the random target is the page latched with 00h.
- R4: While RDY=0 only 70h, 78h and FFh are accepted; every other byte is rejected.
- R5: While RDY=1 and ARDY=0, only 70h, 78h, 00h, 31h, 05h, E0h and FFh can be accepted; 30h and 3Fh are rejected.
- R6: Byte 3Fh is accepted only in cache mode with ARDY=1. The die is then busy for T_CBSY cycles and returns with RDY=1, ARDY=1, the final page in the cache, the data register invalid and cache mode left, so a following 31h is rejected.
- R7: `rd_en` advances `col_ptr` by one per cycle only while RDY=1 and the cache is valid. 05h (latching `col_addr`) followed by E0h loads `col_ptr`, and E0h wins over `rd_en` in the same cycle. `col_ptr` is 0 whenever a new page enters the cache.
- R8: FFh is accepted in any state. It clears both valid flags, stops any background load, holds the die busy for T_RST cycles and then returns it to ready.
- R9: A rejected byte raises `cmd_illegal` for exactly one cycle and leaves the state unchanged. Bytes without a defined meaning (for example A5h) are rejected. `cmd_accept` and `cmd_illegal` are never high together.
- R10: `status_byte` has RDY at bit 6 and ARDY at bit 5, with every other bit 0.
- R11: `dout` equals the low 8 bits of the cache page plus the low 8 bits of `col_ptr`, modulo 256.
- R12: A 31h issued while the background load is still running keeps the die busy until that load finishes, even when this takes longer than T_CBSY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A command byte is present this cycle |
| cmd_byte | input | 8 | Command byte |
| page_addr | input | PAGE_W | Page number latched with byte 00h |
| col_addr | input | COL_W | Column latched with byte 05h |
| rd_en | input | 1 | Read strobe, advances the column pointer |
| rb_n | output | 1 | Ready/busy line, low while busy |
| sts_rdy | output | 1 | Die ready flag |
| sts_ardy | output | 1 | Array ready flag |
| status_byte | output | 8 | Status read value |
| cmd_accept | output | 1 | One-cycle pulse: previous byte accepted |
| cmd_illegal | output | 1 | One-cycle pulse: previous byte rejected |
| cache_valid | output | 1 | Cache register holds a page |
| cache_page | output | PAGE_W | Page number in the cache register |
| data_valid | output | 1 | Data register holds a fully loaded page |
| data_page | output | PAGE_W | Page number in (or loading into) the data register |
| col_ptr | output | COL_W | Current output column |
| dout | output | 8 | Output byte for the current column |

## Verification
Two pairs of events can land on the same clock edge. The first is the end of the cache-busy time and the completion of the background load. The bench provokes this by issuing a second 31h in the cycle right after the die returns from the first one. It then expects a busy time of T_RD-1 cycles, the cache holding the first prefetched page and a fresh load of the next page. The second pair is E0h and `rd_en` in one cycle; the column pointer must then equal the latched column, not that column plus one.

// File: rtl/nct_pkg.sv
// Package nct_pkg
// Shared command classes and die states for the cache-read tracker.
// Assumes one command byte per clock; multi-byte commands are tracked
// as prefix plus confirm byte by the top module.
package nct_pkg;

    typedef enum logic [3:0] {
        K_STATUS,   // 70h or 78h
        K_RESET,    // FFh
        K_OPEN,     // 00h, read setup prefix
        K_PLAIN,    // 30h, plain page read confirm
        K_CACHE,    // 31h, cache read (sequential alone, random after 00h)
        K_FINAL,    // 3Fh, final cache read
        K_COLSET,   // 05h, column change prefix
        K_COLGO,    // E0h, column change confirm
        K_UNKNOWN
    } cmd_kind_t;

    typedef enum logic [2:0] {
        ST_READY,
        ST_ARRAY,   // plain page read, fully busy
        ST_CBUSY,   // cache hand-over busy
        ST_FINAL,   // final page hand-over busy
        ST_RST      // reset delay
    } die_state_t;

endpackage

// File: rtl/nct_cmd_decode.sv
// Module nct_cmd_decode
// Maps a raw command byte to a command class. Purely combinational.
// Assumes any byte outside the handled set is to be rejected later.
module nct_cmd_decode
    import nct_pkg::*;
(
    input  logic [7:0] cmd_byte,
    output cmd_kind_t  kind
);

    // Byte-to-class lookup.
    always_comb begin
        case (cmd_byte)
            8'h70, 8'h78: kind = K_STATUS;
            8'hFF:        kind = K_RESET;
            8'h00:        kind = K_OPEN;
            8'h30:        kind = K_PLAIN;
            8'h31:        kind = K_CACHE;
            8'h3F:        kind = K_FINAL;
            8'h05:        kind = K_COLSET;
            8'hE0:        kind = K_COLGO;
            default:      kind = K_UNKNOWN;
        endcase
    end

endmodule

// File: rtl/nct_cmd_filter.sv
// Module nct_cmd_filter
// Decides whether a decoded command is legal in the current die state.
// Assumes rdy/ardy reflect the registered state of the current cycle and
// that the prefix flags record the previous accepted byte.
module nct_cmd_filter
    import nct_pkg::*;
(
    input  cmd_kind_t kind,
    input  logic      rdy,
    input  logic      ardy,
    input  logic      pre_open,
    input  logic      pre_col,
    input  logic      have_page,
    input  logic      cache_mode,
    input  logic      cache_valid,
    output logic      legal
);

    // Legality table by command class and status combination.
    always_comb begin
        case (kind)
            K_STATUS, K_RESET: legal = 1'b1;
            K_OPEN:            legal = rdy;
            K_PLAIN:           legal = rdy && ardy && pre_open;
            K_CACHE:           legal = rdy && have_page;
            K_FINAL:           legal = rdy && ardy && cache_mode;
            K_COLSET:          legal = rdy && cache_valid;
            K_COLGO:           legal = rdy && pre_col;
            default:           legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/nct_countdown.sv
// Module nct_countdown
// Loadable down-counter used for busy windows. Loading N gives exactly N
// busy cycles; near_done is high in the last busy cycle or when idle.
// Assumes load values are at least 1.
module nct_countdown #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             clear,
    input  logic [CNT_W-1:0] load_val,
    output logic             busy,
    output logic             near_done
);

    logic [CNT_W-1:0] cnt;

    // Count register: clear beats load beats decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (clear)        cnt <= '0;
        else if (load)         cnt <= load_val;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign busy      = (cnt != '0);
    assign near_done = (cnt <= CNT_W'(1));

endmodule

// File: rtl/nand_cache_read_tracker.sv
// Module nand_cache_read_tracker
// Device-side model of one NAND die's read and cache-read state machine.
// Tracks a data-register slot and a cache-register slot as valid+page tags,
// generates ready/busy and status flags, and filters commands by state.
// Assumes one command byte per clock, page and column presented with the
// 00h and 05h bytes, and all timing parameters at least 1.
module nand_cache_read_tracker
    import nct_pkg::*;
#(
    parameter int PAGE_W = 12,
    parameter int COL_W  = 12,
    parameter int T_RD   = 20,
    parameter int T_CBSY = 4,
    parameter int T_RST  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_byte,
    input  logic [PAGE_W-1:0] page_addr,
    input  logic [COL_W-1:0]  col_addr,
    input  logic              rd_en,
    output logic              rb_n,
    output logic              sts_rdy,
    output logic              sts_ardy,
    output logic [7:0]        status_byte,
    output logic              cmd_accept,
    output logic              cmd_illegal,
    output logic              cache_valid,
    output logic [PAGE_W-1:0] cache_page,
    output logic              data_valid,
    output logic [PAGE_W-1:0] data_page,
    output logic [COL_W-1:0]  col_ptr,
    output logic [7:0]        dout
);

    localparam int T_MAX = (T_RD > T_CBSY) ? ((T_RD > T_RST) ? T_RD : T_RST)
                                           : ((T_CBSY > T_RST) ? T_CBSY : T_RST);
    localparam int CNT_W = $clog2(T_MAX + 1);

    die_state_t        state;
    cmd_kind_t         kind;
    logic              legal, take;
    logic              rdy, ardy;
    logic              pre_open, pre_col, cache_mode;
    logic [PAGE_W-1:0] pend_page, last_req, next_tgt, tgt_page;
    logic [COL_W-1:0]  pend_col;
    logic              main_load, main_busy, main_last;
    logic [CNT_W-1:0]  main_val;
    logic              bg_load, bg_clear, bg_busy, bg_last;
    logic              busy_exit;

    assign rdy  = (state == ST_READY);
    assign ardy = rdy && !bg_busy;
    assign take = cmd_valid && legal;

    nct_cmd_decode u_dec (
        .cmd_byte (cmd_byte),
        .kind     (kind)
    );

    nct_cmd_filter u_filt (
        .kind        (kind),
        .rdy         (rdy),
        .ardy        (ardy),
        .pre_open    (pre_open),
        .pre_col     (pre_col),
        .have_page   (data_valid || bg_busy),
        .cache_mode  (cache_mode),
        .cache_valid (cache_valid),
        .legal       (legal)
    );

    // Foreground timer: full-busy windows (array read, hand-over, reset).
    nct_countdown #(.CNT_W(CNT_W)) u_main_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (main_load),
        .clear     (1'b0),
        .load_val  (main_val),
        .busy      (main_busy),
        .near_done (main_last)
    );

    // Background timer: array load into the data register during cache mode.
    nct_countdown #(.CNT_W(CNT_W)) u_bg_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (bg_load),
        .clear     (bg_clear),
        .load_val  (CNT_W'(T_RD)),
        .busy      (bg_busy),
        .near_done (bg_last)
    );

    // Target page of a cache command: latched page if prefixed, else next.
    assign tgt_page = pre_open ? pend_page : (last_req + 1'b1);

    // Foreground timer load selection on accepted commands.
    always_comb begin
        main_load = 1'b0;
        main_val  = CNT_W'(T_CBSY);
        if (take) begin
            case (kind)
                K_RESET: begin main_load = 1'b1; main_val = CNT_W'(T_RST); end
                K_PLAIN: begin main_load = 1'b1; main_val = CNT_W'(T_RD);  end
                K_CACHE, K_FINAL: begin main_load = 1'b1; main_val = CNT_W'(T_CBSY); end
                default: ;
            endcase
        end
    end

    // End of a busy window; a hand-over also waits for the background load.
    always_comb begin
        case (state)
            ST_ARRAY, ST_FINAL, ST_RST: busy_exit = main_last;
            ST_CBUSY:                   busy_exit = main_last && bg_last;
            default:                    busy_exit = 1'b0;
        endcase
    end

    assign bg_clear = take && (kind == K_RESET);
    assign bg_load  = !bg_clear && busy_exit && (state == ST_CBUSY);

    // Die state, slot tags, prefixes and column pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_READY;
            cmd_accept  <= 1'b0;
            cmd_illegal <= 1'b0;
            pre_open    <= 1'b0;
            pre_col     <= 1'b0;
            cache_mode  <= 1'b0;
            pend_page   <= '0;
            last_req    <= '0;
            next_tgt    <= '0;
            pend_col    <= '0;
            cache_valid <= 1'b0;
            cache_page  <= '0;
            data_valid  <= 1'b0;
            data_page   <= '0;
            col_ptr     <= '0;
        end else begin
            cmd_accept  <= take;
            cmd_illegal <= cmd_valid && !legal;
            if (take && kind == K_RESET) begin
                state       <= ST_RST;
                pre_open    <= 1'b0;
                pre_col     <= 1'b0;
                cache_mode  <= 1'b0;
                cache_valid <= 1'b0;
                data_valid  <= 1'b0;
                col_ptr     <= '0;
            end else begin
                if (rd_en && rdy && cache_valid)
                    col_ptr <= col_ptr + 1'b1;
                if (bg_busy && bg_last)
                    data_valid <= 1'b1;
                if (take) begin
                    case (kind)
                        K_OPEN: begin
                            pre_open  <= 1'b1;
                            pre_col   <= 1'b0;
                            pend_page <= page_addr;
                        end
                        K_PLAIN: begin
                            state       <= ST_ARRAY;
                            pre_open    <= 1'b0;
                            pre_col     <= 1'b0;
                            last_req    <= pend_page;
                            data_page   <= pend_page;
                            data_valid  <= 1'b0;
                            cache_valid <= 1'b0;
                            cache_mode  <= 1'b0;
                        end
                        K_CACHE: begin
                            state    <= ST_CBUSY;
                            pre_open <= 1'b0;
                            pre_col  <= 1'b0;
                            last_req <= tgt_page;
                            next_tgt <= tgt_page;
                        end
                        K_FINAL: begin
                            state    <= ST_FINAL;
                            pre_open <= 1'b0;
                            pre_col  <= 1'b0;
                        end
                        K_COLSET: begin
                            pre_col  <= 1'b1;
                            pre_open <= 1'b0;
                            pend_col <= col_addr;
                        end
                        K_COLGO: begin
                            pre_col  <= 1'b0;
                            pre_open <= 1'b0;
                            col_ptr  <= pend_col;
                        end
                        default: ;
                    endcase
                end
                if (busy_exit) begin
                    state <= ST_READY;
                    case (state)
                        ST_ARRAY: begin
                            data_valid  <= 1'b1;
                            cache_valid <= 1'b1;
                            cache_page  <= data_page;
                            col_ptr     <= '0;
                        end
                        ST_CBUSY: begin
                            cache_valid <= 1'b1;
                            cache_page  <= data_page;
                            col_ptr     <= '0;
                            data_page   <= next_tgt;
                            data_valid  <= 1'b0;
                            cache_mode  <= 1'b1;
                        end
                        ST_FINAL: begin
                            cache_valid <= 1'b1;
                            cache_page  <= data_page;
                            col_ptr     <= '0;
                            data_valid  <= 1'b0;
                            cache_mode  <= 1'b0;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    assign rb_n        = rdy;
    assign sts_rdy     = rdy;
    assign sts_ardy    = ardy;
    assign status_byte = {1'b0, rdy, ardy, 5'b0};
    assign dout        = 8'(cache_page) + 8'(col_ptr);

endmodule

// File: rtl/nct_checker.sv
// Module nct_checker
// Protocol and state checks for nand_cache_read_tracker, attached by bind.
// Assumes the synchronous active-low reset of the checked block.
module nct_checker #(
    parameter int PAGE_W = 12,
    parameter int COL_W  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [7:0]        cmd_byte,
    input logic              sts_rdy,
    input logic              sts_ardy,
    input logic              cmd_accept,
    input logic              cmd_illegal,
    input logic              cache_valid,
    input logic [PAGE_W-1:0] cache_page,
    input logic              data_valid,
    input logic              rb_n,
    input logic [COL_W-1:0]  col_ptr
);

    // R9
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_accept && cmd_illegal));

    // R4
    busy_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !sts_rdy && cmd_byte != 8'h70 && cmd_byte != 8'h78 &&
        cmd_byte != 8'hFF |=> cmd_illegal);

    // R5
    plain_in_cache_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_byte == 8'h30 && sts_rdy && !sts_ardy |=> cmd_illegal);

    // R6
    final_needs_ardy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_byte == 8'h3F && !sts_ardy |=> cmd_illegal);

    // R7
    col_zero_new_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_rdy && !$stable(cache_page)) || $rose(cache_valid) |-> col_ptr == '0);

    // R8
    reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_byte == 8'hFF |=> !cache_valid && !data_valid && !rb_n);

    // R3
    cache_readable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sts_rdy && !sts_ardy |-> cache_valid);

endmodule

bind nand_cache_read_tracker nct_checker #(.PAGE_W(PAGE_W), .COL_W(COL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_byte    (cmd_byte),
    .sts_rdy     (sts_rdy),
    .sts_ardy    (sts_ardy),
    .cmd_accept  (cmd_accept),
    .cmd_illegal (cmd_illegal),
    .cache_valid (cache_valid),
    .cache_page  (cache_page),
    .data_valid  (data_valid),
    .rb_n        (rb_n),
    .col_ptr     (col_ptr)
);

// File: tb/nand_cache_read_tracker_test.sv
`timescale 1ns/1ps
// Directed bench for nand_cache_read_tracker: one task per scenario.
module nand_cache_read_tracker_test;

    localparam int PAGE_W = 12;
    localparam int COL_W  = 12;
    localparam int T_RD   = 20;
    localparam int T_CBSY = 4;
    localparam int T_RST  = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [7:0]        cmd_byte = 8'h00;
    logic [PAGE_W-1:0] page_addr = '0;
    logic [COL_W-1:0]  col_addr = '0;
    logic              rd_en = 1'b0;
    logic              rb_n, sts_rdy, sts_ardy, cmd_accept, cmd_illegal;
    logic              cache_valid, data_valid;
    logic [7:0]        status_byte, dout;
    logic [PAGE_W-1:0] cache_page, data_page;
    logic [COL_W-1:0]  col_ptr;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    nand_cache_read_tracker #(
        .PAGE_W(PAGE_W), .COL_W(COL_W), .T_RD(T_RD), .T_CBSY(T_CBSY), .T_RST(T_RST)
    ) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .page_addr(page_addr), .col_addr(col_addr), .rd_en(rd_en),
        .rb_n(rb_n), .sts_rdy(sts_rdy), .sts_ardy(sts_ardy),
        .status_byte(status_byte), .cmd_accept(cmd_accept), .cmd_illegal(cmd_illegal),
        .cache_valid(cache_valid), .cache_page(cache_page), .data_valid(data_valid),
        .data_page(data_page), .col_ptr(col_ptr), .dout(dout)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Present one byte for one edge; return the pulses seen after it.
    task automatic send(input logic [7:0] b, output logic acc, output logic ill);
        cmd_valid = 1'b1;
        cmd_byte  = b;
        @(negedge clk);
        acc = cmd_accept;
        ill = cmd_illegal;
        cmd_valid = 1'b0;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (!rb_n && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic wait_ardy();
        int n = 0;
        while (!sts_ardy && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset_state();
        check(rb_n && sts_rdy && sts_ardy, "R1 ready flags", {rb_n, sts_rdy, sts_ardy}, 3'b111);
        check(!cache_valid && !data_valid, "R1 slots empty", {cache_valid, data_valid}, 0);
        check(col_ptr == 0 && !cmd_accept && !cmd_illegal, "R1 col/pulses", col_ptr, 0);
        check(status_byte == 8'h60, "R10 idle status", status_byte, 8'h60);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check(col_ptr == 0, "R7 rd_en ignored with empty cache", col_ptr, 0);
    endtask

    task automatic t_plain_read();
        logic a, i;
        int n;
        page_addr = 12'h123;
        send(8'h00, a, i);
        check(a && !i, "R2 00h accepted", {a, i}, 2'b10);
        send(8'h30, a, i);
        check(a && !sts_ardy && status_byte == 8'h00, "R10 busy status", status_byte, 8'h00);
        count_busy(n);
        check(n == T_RD, "R2 busy length", n, T_RD);
        check(cache_valid && data_valid && cache_page == 12'h123 && data_page == 12'h123,
              "R2 slots loaded", cache_page, 12'h123);
        check(col_ptr == 0 && sts_ardy, "R2 col zero, idle", col_ptr, 0);
    endtask

    task automatic t_busy_filter();
        logic a, i;
        int n;
        page_addr = 12'h040;
        send(8'h00, a, i);
        send(8'h30, a, i);
        send(8'h05, a, i);
        check(i && !a, "R4 05h rejected while busy", {a, i}, 2'b01);
        send(8'h70, a, i);
        check(a && !i, "R4 70h accepted while busy", {a, i}, 2'b10);
        send(8'h78, a, i);
        check(a && !i && !rb_n, "R4 78h accepted, still busy", {a, i, rb_n}, 3'b100);
        count_busy(n);
        check(cache_page == 12'h040, "R2 second page", cache_page, 12'h040);
    endtask

    task automatic t_column();
        logic a, i;
        rd_en = 1'b1;
        repeat (3) @(negedge clk);
        rd_en = 1'b0;
        check(col_ptr == 3, "R7 three strobes", col_ptr, 3);
        check(dout == 8'h43, "R11 dout", dout, 8'h43);
        col_addr = 12'h010;
        send(8'h05, a, i);
        rd_en = 1'b1;
        send(8'hE0, a, i);
        rd_en = 1'b0;
        check(a && col_ptr == 12'h010, "R7 E0h beats rd_en", col_ptr, 12'h010);
        check(dout == 8'h50, "R11 dout after column change", dout, 8'h50);
    endtask

    task automatic t_cache_flow();
        logic a, i;
        int n;
        send(8'h31, a, i);
        check(a, "R3 31h accepted", a, 1);
        count_busy(n);
        check(n == T_CBSY, "R3 cache-busy length", n, T_CBSY);
        check(cache_page == 12'h040 && data_page == 12'h041 && !sts_ardy && col_ptr == 0,
              "R3 hand-over", data_page, 12'h041);
        check(status_byte == 8'h40, "R10 cache status", status_byte, 8'h40);
        send(8'h31, a, i);
        count_busy(n);
        check(n == T_RD - 1, "R12 waits for array", n, T_RD - 1);
        check(cache_page == 12'h041 && data_page == 12'h042 && !sts_ardy,
              "R12 pages after wait", cache_page, 12'h041);
        send(8'h30, a, i);
        check(i && !a, "R5 30h rejected", {a, i}, 2'b01);
        @(negedge clk);
        check(!cmd_illegal && rb_n && cache_page == 12'h041, "R9 one-cycle pulse", cmd_illegal, 0);
        send(8'h3F, a, i);
        check(i, "R5 3Fh rejected with ARDY low", i, 1);
        send(8'h05, a, i);
        check(a, "R5 05h accepted with ARDY low", a, 1);
        wait_ardy();
        page_addr = 12'h200;
        send(8'h00, a, i);
        send(8'h31, a, i);
        count_busy(n);
        check(n == T_CBSY && cache_page == 12'h042 && data_page == 12'h200,
              "R3 random target", data_page, 12'h200);
        wait_ardy();
        send(8'h3F, a, i);
        check(a, "R6 3Fh accepted", a, 1);
        count_busy(n);
        check(n == T_CBSY, "R6 final busy length", n, T_CBSY);
        check(cache_page == 12'h200 && sts_ardy && !data_valid && col_ptr == 0,
              "R6 final page", cache_page, 12'h200);
        send(8'h31, a, i);
        check(i && rb_n, "R6 31h after final rejected", i, 1);
    endtask

    task automatic t_abort();
        logic a, i;
        int n;
        send(8'hA5, a, i);
        check(i && !a && rb_n && cache_valid, "R9 unknown byte", {a, i}, 2'b01);
        page_addr = 12'h077;
        send(8'h00, a, i);
        send(8'h30, a, i);
        repeat (3) @(negedge clk);
        send(8'hFF, a, i);
        check(a && !cache_valid && !data_valid, "R8 reset clears", {cache_valid, data_valid}, 0);
        count_busy(n);
        check(n == T_RST && sts_ardy, "R8 reset delay", n, T_RST);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_plain_read();
        t_busy_filter();
        t_column();
        t_cache_flow();
        t_abort();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule